// File: doc/BRIEF.md
# Matrix Keyboard Scanner with Multi-Key Alarm

The block drives the rows of a key matrix one at a time and reads the column sense lines back. A single key is accepted only after it has been seen at the same row and column on a set number of consecutive full scans. The block then places a position code on its output bus and marks it with a one-clock strobe. After a key has been accepted, the block waits until the whole matrix has been released and stays quiet before it takes another key.

A housekeeping section guards against overlapping key presses. If a second closure appears before the first has been accepted, the block raises an alarm line and stops encoding. When a configuration input is set, it also sends a reserved all-ones code on the bus. The alarm is held, and encoding stays blocked, until every key has been released and an idle interval has passed. That interval is the debounce count plus two more scan cycles with no key down. A key pressed during the interval restarts the count.

Top module: `kbd_scan_alarm`

## Requirements
- R1: While synchronous reset is high and on the first cycle after it, row_drv drives row 0 only (bit 0 set), and key_strobe, alarm and key_code are all zero.
- R2: row_drv always has exactly one bit set. It moves to the next higher row once every SCAN_DIV clocks and wraps from the top row back to row 0.
- R3: Column inputs are active high and pass through a two-flop synchronizer. A key at (row r, column c) is seen when row r is driven and column c reads high.
- R4: A lone key seen at the same position on DEB_SCANS consecutive scan cycles (default 4) produces exactly one key_strobe pulse, one clock wide. key_code equals the row index in the upper bits concatenated with the column index in the lower bits, so (2,1) gives 9 and (0,3) gives 3 on a 4x4 matrix.
- R5: A lone key held for fewer than DEB_SCANS scan cycles produces no strobe.
- R6: Two or more closures within one scan cycle, while no key has yet been accepted, raise alarm. This covers a second key added during the debounce of the first, and two keys on the same row.
- R7: At alarm onset with bus_alarm_en = 1, one strobe is sent with key_code all ones (15 on a 4x4 matrix). With bus_alarm_en = 0, no strobe is sent.
- R8: While alarm is high, no key code is strobed, even if only one key is still held.
- R9: The alarm drops, and encoding is re-armed, after DEB_SCANS + 2 consecutive full scan cycles with no key down. A closure during that interval restarts the count.
- R10: Once a key has been accepted, extra keys pressed while it is held raise no alarm and give no strobe. The next code needs a full release followed by the quiet interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col_in | input | COLS | Column sense lines, active high, asynchronous |
| bus_alarm_en | input | 1 | 1: the alarm onset is also sent on the bus as an all-ones code |
| row_drv | output | ROWS | One-hot row drive |
| key_code | output | RBITS+CBITS | Row index and column index of the accepted key |
| key_strobe | output | 1 | One-clock valid pulse for key_code |
| alarm | output | 1 | Multi-key alarm level |

## Verification
The assertions assume that the column lines follow the driven row within a few clocks. They also assume that each key stays steady for many scan cycles, so that a scan never sees a half-settled matrix. The bench models the matrix as a simple OR of the pressed keys on the driven row. It changes keys only on the falling clock edge and holds every press or release for whole scan cycles. It also assumes bus_alarm_en changes only while the block is idle. The bench sets it only after a quiet interval, so the alarm onset always sees a stable enable.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
  typedef enum logic [0:0] {
    ST_ARMED  = 1'b0,
    ST_LOCKED = 1'b1
  } kbd_state_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/kbd_row_scan.sv
module kbd_row_scan #(
  parameter int ROWS     = 4,
  parameter int SCAN_DIV = 8,
  parameter int RBITS    = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic [ROWS-1:0]  row_drv,
  output logic [RBITS-1:0] row_idx,
  output logic             tick,
  output logic             scan_end
);
  localparam int DW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;

  logic [DW-1:0]    div_q;
  logic [RBITS-1:0] row_q;
  logic [ROWS-1:0]  drv_q;

  assign tick     = (div_q == DW'(SCAN_DIV - 1));
  assign scan_end = tick && (row_q == RBITS'(ROWS - 1));
  assign row_idx  = row_q;
  assign row_drv  = drv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      row_q <= '0;
      drv_q <= ROWS'(1);
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        row_q <= (row_q == RBITS'(ROWS - 1)) ? '0 : row_q + 1'b1;
        drv_q <= {drv_q[ROWS-2:0], drv_q[ROWS-1]};
      end
    end
  end
endmodule

// File: rtl/kbd_col_sync.sv
module kbd_col_sync #(
  parameter int COLS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [COLS-1:0] col_in,
  output logic [COLS-1:0] col_sync
);
  for (genvar i = 0; i < COLS; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= col_in[i];
        sync_q <= meta_q;
      end
    end
    assign col_sync[i] = sync_q;
  end
endmodule

// File: rtl/kbd_ctrl.sv
module kbd_ctrl
  import kbd_scan_pkg::*;
#(
  parameter int COLS       = 4,
  parameter int RBITS      = 2,
  parameter int CBITS      = 2,
  parameter int DEB_SCANS  = 4,
  parameter int IDLE_EXTRA = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic                   scan_end,
  input  logic [RBITS-1:0]       row_idx,
  input  logic [COLS-1:0]        cols,
  input  logic                   bus_alarm_en,
  output logic [RBITS+CBITS-1:0] key_code,
  output logic                   key_strobe,
  output logic                   alarm
);
  localparam int CODE_W = RBITS + CBITS;
  localparam int QUIET  = DEB_SCANS + IDLE_EXTRA;
  localparam int DBW    = $clog2(DEB_SCANS + 1);
  localparam int QW     = $clog2(QUIET + 1);

  kbd_state_e        state_q;
  logic [1:0]        hits_q;
  logic [CODE_W-1:0] first_q, cand_q, code_q;
  logic [DBW-1:0]    deb_q;
  logic [QW-1:0]     quiet_q;
  logic              strobe_q, alarm_q;

  // closures on the current row, saturated at two
  logic [1:0]        row_n;
  logic [2:0]        sum;
  logic [1:0]        tot;
  logic [CBITS-1:0]  low_col;
  logic [CODE_W-1:0] pos;
  logic [DBW:0]      next_deb;

  always_comb begin
    row_n = (cols == '0) ? 2'd0 : ($onehot(cols) ? 2'd1 : 2'd2);
    sum   = {1'b0, hits_q} + {1'b0, row_n};
    tot   = (sum >= 3'd2) ? 2'd2 : sum[1:0];
    low_col = '0;
    for (int c = COLS - 1; c >= 0; c--)
      if (cols[c]) low_col = CBITS'(c);
    pos = (hits_q == 2'd0) ? {row_idx, low_col} : first_q;
    next_deb = (deb_q != '0 && pos == cand_q) ? {1'b0, deb_q} + 1'b1
                                               : (DBW+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_ARMED;
      hits_q   <= '0;
      first_q  <= '0;
      cand_q   <= '0;
      code_q   <= '0;
      deb_q    <= '0;
      quiet_q  <= '0;
      strobe_q <= 1'b0;
      alarm_q  <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (tick && !scan_end) begin
        hits_q <= tot;
        if (hits_q == 2'd0 && row_n != 2'd0) first_q <= {row_idx, low_col};
      end
      if (scan_end) begin
        hits_q <= '0;
        case (state_q)
          ST_ARMED: begin
            if (tot == 2'd0) begin
              deb_q <= '0;
            end else if (tot == 2'd1) begin
              cand_q <= pos;
              if (next_deb >= (DBW+1)'(DEB_SCANS)) begin
                code_q   <= pos;
                strobe_q <= 1'b1;
                deb_q    <= '0;
                quiet_q  <= '0;
                state_q  <= ST_LOCKED;
              end else begin
                deb_q <= next_deb[DBW-1:0];
              end
            end else begin
              alarm_q <= 1'b1;
              deb_q   <= '0;
              quiet_q <= '0;
              state_q <= ST_LOCKED;
              if (bus_alarm_en) begin
                code_q   <= '1;
                strobe_q <= 1'b1;
              end
            end
          end
          ST_LOCKED: begin
            if (tot != 2'd0) begin
              quiet_q <= '0;
            end else if (quiet_q == QW'(QUIET - 1)) begin
              quiet_q <= '0;
              alarm_q <= 1'b0;
              state_q <= ST_ARMED;
            end else begin
              quiet_q <= quiet_q + 1'b1;
            end
          end
          default: state_q <= ST_ARMED;
        endcase
      end
    end
  end

  assign key_code   = code_q;
  assign key_strobe = strobe_q;
  assign alarm      = alarm_q;
endmodule

// File: rtl/kbd_scan_alarm.sv
module kbd_scan_alarm
  import kbd_scan_pkg::*;
#(
  parameter int ROWS       = 4,
  parameter int COLS       = 4,
  parameter int SCAN_DIV   = 8,
  parameter int DEB_SCANS  = 4,
  parameter int IDLE_EXTRA = 2,
  localparam int RBITS     = idx_bits(ROWS),
  localparam int CBITS     = idx_bits(COLS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [COLS-1:0]        col_in,
  input  logic                   bus_alarm_en,
  output logic [ROWS-1:0]        row_drv,
  output logic [RBITS+CBITS-1:0] key_code,
  output logic                   key_strobe,
  output logic                   alarm
);
  logic [RBITS-1:0] row_idx;
  logic             tick, scan_end;
  logic [COLS-1:0]  col_sync;

  kbd_row_scan #(.ROWS(ROWS), .SCAN_DIV(SCAN_DIV), .RBITS(RBITS)) u_scan (
    .clk(clk), .rst(rst), .row_drv(row_drv), .row_idx(row_idx),
    .tick(tick), .scan_end(scan_end)
  );

  kbd_col_sync #(.COLS(COLS)) u_sync (
    .clk(clk), .rst(rst), .col_in(col_in), .col_sync(col_sync)
  );

  kbd_ctrl #(
    .COLS(COLS), .RBITS(RBITS), .CBITS(CBITS),
    .DEB_SCANS(DEB_SCANS), .IDLE_EXTRA(IDLE_EXTRA)
  ) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .scan_end(scan_end),
    .row_idx(row_idx), .cols(col_sync), .bus_alarm_en(bus_alarm_en),
    .key_code(key_code), .key_strobe(key_strobe), .alarm(alarm)
  );
endmodule

// File: rtl/kbd_scan_alarm_chk.sv
module kbd_scan_alarm_chk #(
  parameter int ROWS   = 4,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_alarm_en,
  input logic [ROWS-1:0]   row_drv,
  input logic [CODE_W-1:0] key_code,
  input logic              key_strobe,
  input logic              alarm
);
  logic [ROWS-1:0] prev_q;
  logic            prev_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ok <= 1'b0;
      prev_q  <= '0;
    end else begin
      prev_ok <= 1'b1;
      prev_q  <= row_drv;
    end
  end

  // R2: one row at a time
  a_r2_row_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(row_drv) == 1);

  // R2: rows advance by one position with wrap
  a_r2_row_step: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && row_drv != prev_q) |-> row_drv == {prev_q[ROWS-2:0], prev_q[ROWS-1]});

  // R4: strobe is one clock wide
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
    key_strobe |=> !key_strobe);

  // R7: alarm onset on the bus when enabled
  a_r7_alarm_bus: assert property (@(posedge clk) disable iff (rst)
    ($rose(alarm) && $past(bus_alarm_en)) |-> (key_strobe && (&key_code)));

  // R7: alarm onset stays off the bus when disabled
  a_r7_alarm_silent: assert property (@(posedge clk) disable iff (rst)
    ($rose(alarm) && !$past(bus_alarm_en)) |-> !key_strobe);

  // R8: no codes while the alarm persists
  a_r8_locked: assert property (@(posedge clk) disable iff (rst)
    (alarm && $past(alarm)) |-> !key_strobe);
endmodule

bind kbd_scan_alarm kbd_scan_alarm_chk #(.ROWS(ROWS), .CODE_W(RBITS+CBITS)) u_chk (
  .clk(clk), .rst(rst), .bus_alarm_en(bus_alarm_en), .row_drv(row_drv),
  .key_code(key_code), .key_strobe(key_strobe), .alarm(alarm)
);

// File: tb/kbd_scan_alarm_test.sv
module kbd_scan_alarm_test;
  localparam int ROWS = 4, COLS = 4, SCAN_DIV = 8;
  localparam int SCAN = ROWS * SCAN_DIV;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [COLS-1:0] col_in;
  logic            bus_alarm_en = 1'b1;
  logic [ROWS-1:0] row_drv;
  logic [3:0]      key_code;
  logic            key_strobe;
  logic            alarm;
  logic [ROWS*COLS-1:0] keys = '0;

  int checks = 0, fails = 0, strobes = 0;
  bit done = 1'b0;
  logic [3:0] exp_q[$];

  always #2.5 clk = ~clk;

  kbd_scan_alarm uut (
    .clk(clk), .rst(rst), .col_in(col_in), .bus_alarm_en(bus_alarm_en),
    .row_drv(row_drv), .key_code(key_code), .key_strobe(key_strobe), .alarm(alarm)
  );

  // matrix model: a pressed key connects its row drive to its column
  always_comb begin
    col_in = '0;
    for (int r = 0; r < ROWS; r++)
      if (row_drv[r]) col_in = col_in | keys[r*COLS +: COLS];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && key_strobe) begin
      strobes++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R5/R8/R10 unexpected strobe", key_code, -1);
      end else begin
        automatic logic [3:0] e = exp_q.pop_front();
        check(key_code == e, "R4/R7 strobe code", key_code, e);
      end
    end
  end

  task automatic expect_code(input logic [3:0] c); exp_q.push_back(c); endtask
  task automatic press(input int r, input int c);
    @(negedge clk); keys[r*COLS + c] = 1'b1;
  endtask
  task automatic lift(input int r, input int c);
    @(negedge clk); keys[r*COLS + c] = 1'b0;
  endtask
  task automatic lift_all(); @(negedge clk); keys = '0; endtask
  task automatic scans(input int n); repeat (n * SCAN) @(negedge clk); endtask
  task automatic drained(input string req);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(row_drv == 4'b0001, "R1 row", row_drv, 1);
    check(key_strobe == 1'b0, "R1 strobe", key_strobe, 0);
    check(alarm == 1'b0, "R1 alarm", alarm, 0);
    check(key_code == 4'd0, "R1 code", key_code, 0);

    // R2: rotation over one full scan
    begin
      int chg = 0; bit ok = 1'b1;
      for (int i = 0; i < SCAN; i++) begin
        automatic logic [ROWS-1:0] p = row_drv;
        @(negedge clk);
        if ($countones(row_drv) != 1) ok = 1'b0;
        if (row_drv != p) begin
          chg++;
          if (row_drv != {p[ROWS-2:0], p[ROWS-1]}) ok = 1'b0;
        end
      end
      check(ok && chg == ROWS, "R2 row rotation", chg, ROWS);
    end

    // R3 R4: single keys
    expect_code(4'd9); press(2, 1); scans(10);
    drained("R4 key (2,1)"); check(alarm == 1'b0, "R4 no alarm", alarm, 0);
    lift_all(); scans(10);
    expect_code(4'd3); press(0, 3); scans(10); drained("R3 key (0,3)");
    lift_all(); scans(10);

    // R5: short press
    snap = strobes; press(1, 2); scans(2); lift_all(); scans(10);
    check(strobes == snap, "R5 short press", strobes - snap, 0);

    // R6 R7: two keys together, bus alarm on
    expect_code(4'hF); press(1, 1); press(3, 2); scans(8);
    check(alarm == 1'b1, "R6 alarm set", alarm, 1); drained("R7 alarm code");
    // R8: one key left held while locked
    snap = strobes; lift(3, 2); scans(10);
    check(strobes == snap, "R8 locked single key", strobes - snap, 0);
    // R9: key during quiet restarts the count
    lift_all(); scans(3); press(0, 2); scans(2); lift_all(); scans(5);
    check(alarm == 1'b1, "R9 quiet restarted", alarm, 1);
    scans(4);
    check(alarm == 1'b0, "R9 alarm cleared", alarm, 0);
    expect_code(4'd6); press(1, 2); scans(10); drained("R9 re-armed key");
    lift_all(); scans(10);

    // R7: bus alarm off, two keys on one row
    bus_alarm_en = 1'b0; snap = strobes;
    press(2, 0); press(2, 2); scans(8);
    check(alarm == 1'b1, "R6 same-row alarm", alarm, 1);
    check(strobes == snap, "R7 silent alarm", strobes - snap, 0);
    lift_all(); scans(10);
    check(alarm == 1'b0, "R9 clear after silent", alarm, 0);

    // R6: second key during debounce of first
    bus_alarm_en = 1'b1;
    press(0, 0); scans(2); expect_code(4'hF); press(2, 3); scans(6);
    check(alarm == 1'b1, "R6 overlap alarm", alarm, 1); drained("R7 overlap code");
    lift_all(); scans(10);

    // R10: rollover after acceptance
    expect_code(4'd12); press(3, 0); scans(8); drained("R10 first key");
    snap = strobes; press(0, 1); scans(8);
    check(alarm == 1'b0, "R10 no alarm", alarm, 0);
    lift(3, 0); scans(10);
    check(strobes == snap, "R10 needs release", strobes - snap, 0);
    lift_all(); scans(10);
    expect_code(4'd1); press(0, 1); scans(10); drained("R10 next key");
    lift_all(); scans(4);

    drained("R4 scoreboard empty");
    finish_run();
  end
endmodule